// File: doc/BRIEF.md
# Four-times oversampling bit-clock recovery

This block receives an asynchronous serial line that has no clock with it. It samples the line with a local clock running at four times the nominal bit rate, for example an 80 MHz sample clock for a 20 Mbps stream. The line passes through a synchroniser and an edge detector. A four-state phase counter then tracks where transitions fall. For each bit, the block emits a single bit-enable strobe near the middle of the bit, together with the synchronised line level. The downstream NRZI decoder consumes both.

Every transition is sorted into one of four classes by the counter state it lands in:
- **On time:** the counter continues unchanged.
- **One sample early:** the counter skips a state, so the current bit is one sample shorter.
- **One sample late:** the counter repeats a state, so the current bit is one sample longer.
- **Fourth phase:** a transition at the sampling phase itself means alignment is lost, and the block returns to hunting.

When the line is quiet the counter free-runs. Bit stuffing on the link keeps runs without transitions short.

In hunt, the first transition seeds the counter. After that, a parameterised number of consecutive acceptable transitions is needed before the block reports lock and starts emitting strobes. The gap between these two conditions gives hysteresis between hunting and tracking. Whenever the block falls back to hunting, it raises a one-cycle loss pulse, which the decoder uses to clear its state.

Top module: `os4_clock_recovery`

## Requirements
- R1: `lineIn` passes through two synchroniser flops. A level driven before sample edge k is first used for edge detection, and appears on `bitVal`, in the cycle after edge k+1.
- R2: In hunt, the first detected transition seeds the phase. The sample point falls two sample clocks after the cycle in which that transition is detected.
- R3: Once locked, a transition seen in the expected phase (four samples after the previous accepted transition, modulo four) causes no correction. `bitEn` follows two samples after it.
- R4: A transition seen one sample before the expected phase shortens the current bit by one sample. The spacing between the two `bitEn` strobes around it becomes 3.
- R5: A transition seen one sample after the expected phase lengthens the current bit by one sample. The spacing between the two `bitEn` strobes around it becomes 5.
- R6: A transition seen two samples from the expected phase (the sampling phase) returns the block to hunt from either acquiring or locked. `locked` drops, and `lockLost` is high for exactly one cycle.
- R7: `locked` rises only after LOCK_EDGES (default 4) consecutive on-time, early or late transitions following the seeding transition. `bitEn` is never high while `locked` is low.
- R8: With no transitions, `bitEn` repeats every four sample clocks while locked.
- R9: During and right after reset, `bitEn`, `locked` and `lockLost` are low.
- R10: `bitVal` equals the synchronised line level in every cycle in which `bitEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Asynchronous serial line |
| bitEn | output | 1 | One-cycle strobe at the centre of each recovered bit |
| bitVal | output | 1 | Synchronised line level, valid with `bitEn` |
| locked | output | 1 | High while the phase is being tracked |
| lockLost | output | 1 | One-cycle pulse on falling back to hunt |

## Verification
A phase counter that is off by one state does not hide. At the next transition it shifts the following strobe by a sample, or it misclassifies that transition: a stray edge then drops lock, and an on-time edge then triggers a correction. Both effects show on `bitEn` or `lockLost` within four to six sample clocks. A fault in the acquisition counter moves the rising edge of `locked` by whole transitions, so the first strobe appears a bit period too early or too late. The bench tracks the age of the last accepted transition and, from that age, predicts every output in every cycle.

// File: rtl/os4_cdr_pkg.sv
package os4_cdr_pkg;
  localparam int PHASE_W = 2;
  localparam logic [PHASE_W-1:0] PH_EDGE   = 2'd0;
  localparam logic [PHASE_W-1:0] PH_LATE   = 2'd1;
  localparam logic [PHASE_W-1:0] PH_SAMPLE = 2'd2;
  localparam logic [PHASE_W-1:0] PH_EARLY  = 2'd3;

  typedef enum logic [2:0] {
    EDGE_NONE, EDGE_ONTIME, EDGE_EARLY, EDGE_LATE, EDGE_STRAY
  } edgeKind_t;

  typedef struct packed {
    logic seed;
    logic shorten;
    logic stretch;
  } phaseCmd_t;
endpackage

// File: rtl/os4_cdr_datapath.sv
module os4_cdr_datapath
  import os4_cdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  input  phaseCmd_t cmd,
  output logic      edgeSeen,
  output edgeKind_t edgeKind,
  output logic      samplePoint,
  output logic      lineLevel
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLevel;
  logic [PHASE_W-1:0]     phase;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= lineIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign lineLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= lineLevel;

  assign edgeSeen = lineLevel ^ prevLevel;

  always_comb begin
    edgeKind = EDGE_NONE;
    if (edgeSeen) begin
      unique case (phase)
        PH_EDGE:  edgeKind = EDGE_ONTIME;
        PH_LATE:  edgeKind = EDGE_LATE;
        PH_EARLY: edgeKind = EDGE_EARLY;
        default:  edgeKind = EDGE_STRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            phase <= PH_EDGE;
    else if (cmd.seed)    phase <= PH_EDGE + 2'd1;
    else if (cmd.shorten) phase <= phase + 2'd2;
    else if (cmd.stretch) phase <= phase;
    else                  phase <= phase + 2'd1;

  assign samplePoint = (phase == PH_SAMPLE);
endmodule

// File: rtl/os4_cdr_control.sv
module os4_cdr_control
  import os4_cdr_pkg::*;
#(
  parameter int LOCK_EDGES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  edgeKind_t edgeKind,
  input  logic      samplePoint,
  output phaseCmd_t cmd,
  output logic      bitEn,
  output logic      locked,
  output logic      lockLost
);
  localparam int CNT_W = $clog2(LOCK_EDGES + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_ACQ, ST_LOCK} state_t;

  state_t           state;
  logic [CNT_W-1:0] goodCnt;
  logic             goodEdge;
  logic             strayEdge;

  assign goodEdge  = (edgeKind == EDGE_ONTIME) || (edgeKind == EDGE_EARLY) ||
                     (edgeKind == EDGE_LATE);
  assign strayEdge = (edgeKind == EDGE_STRAY);

  always_comb begin
    cmd.seed    = (state == ST_HUNT) && (edgeKind != EDGE_NONE);
    cmd.shorten = (state != ST_HUNT) && (edgeKind == EDGE_EARLY);
    cmd.stretch = (state != ST_HUNT) && (edgeKind == EDGE_LATE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      goodCnt  <= '0;
      lockLost <= 1'b0;
    end else begin
      lockLost <= 1'b0;
      unique case (state)
        ST_HUNT: if (edgeKind != EDGE_NONE) begin
          state   <= ST_ACQ;
          goodCnt <= '0;
        end
        ST_ACQ: begin
          if (strayEdge) begin
            state    <= ST_HUNT;
            lockLost <= 1'b1;
          end else if (goodEdge) begin
            if (goodCnt == CNT_W'(LOCK_EDGES - 1)) state <= ST_LOCK;
            else                                   goodCnt <= goodCnt + 1'b1;
          end
        end
        ST_LOCK: if (strayEdge) begin
          state    <= ST_HUNT;
          lockLost <= 1'b1;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign locked = (state == ST_LOCK);
  assign bitEn  = locked && samplePoint;
endmodule

// File: rtl/os4_clock_recovery.sv
module os4_clock_recovery
  import os4_cdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_EDGES  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic bitEn,
  output logic bitVal,
  output logic locked,
  output logic lockLost
);
  phaseCmd_t cmd;
  edgeKind_t edgeKind;
  logic      edgeSeen;
  logic      samplePoint;

  os4_cdr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .cmd(cmd),
    .edgeSeen(edgeSeen), .edgeKind(edgeKind),
    .samplePoint(samplePoint), .lineLevel(bitVal)
  );

  os4_cdr_control #(.LOCK_EDGES(LOCK_EDGES)) u_ctl (
    .clk(clk), .rstN(rstN), .edgeKind(edgeKind), .samplePoint(samplePoint),
    .cmd(cmd), .bitEn(bitEn), .locked(locked), .lockLost(lockLost)
  );
endmodule

// File: rtl/os4_cdr_checker.sv
module os4_cdr_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic locked,
  input logic lockLost,
  input logic edgeSeen
);
  // R4: the shortest corrected bit is three samples
  assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> !bitEn);
  assert_min_gap2_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> ##1 !bitEn);
  // R7: no strobe without lock; lock is gained only on a transition
  assert_en_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |-> locked);
  assert_lock_on_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(edgeSeen));
  // R6: loss pulse is single-cycle and coincides with dropping lock
  assert_lost_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockLost |=> !lockLost);
  assert_lost_unlocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockLost |-> !locked);
  assert_drop_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> lockLost);
endmodule

bind os4_clock_recovery os4_cdr_checker u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .locked(locked),
  .lockLost(lockLost), .edgeSeen(edgeSeen)
);

// File: tb/os4_clock_recovery_tb.sv
module os4_clock_recovery_tb;
  localparam int LOCK_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic bitEn, bitVal, locked, lockLost;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference: age of last accepted transition, acquisition state
  logic m1 = 0, m2 = 0, m3 = 0, mLost = 0;
  int   mSt = 0, mCnt = 0, mAge = 0;
  int   lostCount = 0, sinceEn = 0;
  bit   gapSeen [0:31];

  always #4 clk = ~clk;

  os4_clock_recovery u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .bitEn(bitEn), .bitVal(bitVal), .locked(locked), .lockLost(lockLost)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expEn();
    return (mSt == 2) && (mAge % 4 == 2);
  endfunction

  task automatic modelUpdate();
    logic e;
    logic lostN;
    e = m2 ^ m3;
    lostN = 1'b0;
    if (mSt == 0) begin
      if (e) begin mSt = 1; mCnt = 0; mAge = 1; end
      else mAge++;
    end else if (e) begin
      if (mAge % 4 == 2) begin mSt = 0; lostN = 1'b1; mAge++; end
      else begin
        mAge = 1;
        if (mSt == 1) begin
          if (mCnt + 1 == LOCK_N) mSt = 2;
          else mCnt++;
        end
      end
    end else mAge++;
    mLost = lostN;
    m3 = m2; m2 = m1; m1 = lineIn;
  endtask

  task automatic step(input logic nextLine);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    check(bitEn == expEn(), "R3 R4 R5 R8 R2 bitEn", bitEn, expEn());
    check(locked == (mSt == 2), "R7 locked", locked, mSt == 2);
    check(lockLost == mLost, "R6 lockLost", lockLost, mLost);
    if (expEn()) check(bitVal == m2, "R10 R1 bitVal", bitVal, m2);
    if (lockLost) lostCount++;
    sinceEn++;
    if (bitEn) begin
      if (sinceEn < 32) gapSeen[sinceEn] = 1'b1;
      sinceEn = 0;
    end
    lineIn = nextLine;
  endtask

  task automatic sendEdge(input int gap);
    repeat (gap - 1) step(lineIn);
    step(~lineIn);
  endtask

  task automatic clearGaps();
    for (int i = 0; i < 32; i++) gapSeen[i] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int lost0;
    void'($urandom(32'd2718));
    clearGaps();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!bitEn && !locked && !lockLost, "R9 reset outputs", {bitEn, locked, lockLost}, 0);
    rstN = 1'b1;
    repeat (4) step(1'b0);
    check(!locked && !lockLost, "R9 after reset", {locked, lockLost}, 0);

    // seed plus LOCK_N-1 on-time edges: still acquiring
    sendEdge(5);
    repeat (LOCK_N - 1) sendEdge(4);
    repeat (3) step(lineIn);
    check(locked == 1'b0, "R7 not yet locked", locked, 0);
    step(~lineIn);
    repeat (3) step(lineIn);
    check(locked == 1'b1, "R7 locked after edges", locked, 1);

    // quiet line: free-running strobes (R8)
    clearGaps();
    sendEdge(28);
    check(gapSeen[4] && !gapSeen[3] && !gapSeen[5], "R8 free-run gap 4", gapSeen[4], 1);
    sendEdge(8);

    // early edge (R4), late edge (R5)
    clearGaps();
    sendEdge(3);
    repeat (6) step(lineIn);
    check(gapSeen[3], "R4 shortened bit", gapSeen[3], 1);
    sendEdge(2);   // completes 8 since the early edge: on time
    clearGaps();
    sendEdge(5);
    repeat (6) step(lineIn);
    check(gapSeen[5], "R5 lengthened bit", gapSeen[5], 1);
    sendEdge(2);

    // stray edge while locked (R6)
    lost0 = lostCount;
    sendEdge(6);
    repeat (3) step(lineIn);
    check(locked == 1'b0, "R6 lock dropped", locked, 0);
    check(lostCount == lost0 + 1, "R6 single loss pulse", lostCount - lost0, 1);

    // stray edge while acquiring (R6)
    sendEdge(4);
    sendEdge(4);
    lost0 = lostCount;
    sendEdge(6);
    repeat (3) step(lineIn);
    check(lostCount == lost0 + 1, "R6 loss from acquire", lostCount - lost0, 1);

    // random stream with jitter and occasional stray transitions
    for (int n = 0; n < 400; n++) begin
      int k;
      int r;
      int delta;
      k = 1 + $urandom_range(6);
      r = $urandom_range(19);
      delta = (r == 0) ? 2 : (r < 4) ? -1 : (r < 8) ? 1 : 0;
      sendEdge(4 * k + delta);
    end
    repeat (10) step(lineIn);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule